// File: doc/BRIEF.md
# SPI Two-Port Output Expander Register Interface

This block is the serial front end of a small output expander. A host addresses it over a four-wire SPI link in mode 0 (idle clock low, data sampled on the rising clock edge, MSB first). Each chip-select window carries a frame. The frame opens with a 16-bit header. The first header byte is the operation, and the upper nibble of the second header byte is the starting port index. One or more data bytes follow the header. The block samples the serial pins in its own system clock domain through synchronisers, so the serial clock must be several times slower than the system clock.

A frame with one data byte touches one port register. Each further byte moves an internal pointer to the next port. In write frames the bytes land in successive output registers. In read frames the bytes return those registers on the serial output. When the pointer is already on the last port, any further bytes are dropped: they change nothing and never wrap around to port 0. The output registers drive parallel pins directly.

Top module: `spi_gpx_regif`

## Requirements
- R1: After reset all port registers read 0x00 and the serial output enable is low.
- R2: A frame of header 0x03,0x00 followed by one data byte writes that byte to port 0 and leaves port 1 unchanged.
- R3: The port index is the upper nibble of the second header byte (bits 7:4): header 0x03,0x10 writes port 1, and header 0x02,0x10 reads port 1 first.
- R4: In a write burst, data byte k (counting from 0) goes to port (start + k). A frame 0x03,0x00,A,B sets port 0 to A and port 1 to B. At most one port register changes in any system clock cycle.
- R5: Once the pointer has reached the last port, any further data bytes in the frame are dropped. They corrupt no register and do not wrap to port 0.
- R6: Opcode 0x02 reads. Starting at the header's port, each data byte slot returns the next port register on the serial output, MSB first, with the output changing on the falling serial clock. Slots past the last port return 0x00.
- R7: A first header byte other than 0x03 or 0x02 makes the whole frame have no effect. Registers stay unchanged and the serial output stays 0.
- R8: A data byte is committed only when all 8 of its bits have arrived. A partial trailing byte at chip-select release is discarded.
- R9: Chip-select release clears the bit count, the header and the pointer, so the next frame decodes from its first bit. Port registers do not change while chip select is high.
- R10: The serial output enable is high while chip select is low and low while chip select is high, after the synchroniser delay. When the enable is low, the output must be treated as high-impedance.
- R11: A header port index at or above the number of ports makes all data bytes of that frame be dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| port_q | output | NUM_PORTS*8 | Port registers; port n occupies bits [8n+7:8n] |

## Verification
The hardest case to reach is a frame that runs past the last port. It must be shown that the extra bytes neither land anywhere nor wrap around. The bench starts a burst at port 1 and sends three data bytes. Port 0 holds a known non-zero value beforehand, so a wrap would show up on it. For reads, the same over-run appears as 0x00 slots. These slots are checked by a bit-level monitor on the serial output. Partial frames are built by stopping the clock part-way through a byte or a header before releasing chip select. Each is followed by a clean frame, which shows that no state has carried over.

// File: rtl/spi_gpx_pkg.sv
package spi_gpx_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_READ  = 8'h02;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_BAD   = 2'd3
  } op_e;
endpackage

// File: rtl/spi_gpx_sync.sv
module spi_gpx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_r, cs_r, mosi_r;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r <= '0;
      cs_r   <= '1;
      mosi_r <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_r <= {sclk_r[STAGES-2:0], sclk_i};
      cs_r   <= {cs_r[STAGES-2:0], cs_n_i};
      mosi_r <= {mosi_r[STAGES-2:0], mosi_i};
      sclk_d <= sclk_r[STAGES-1];
    end
  end

  assign sclk_rise = sclk_r[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_r[STAGES-1] & sclk_d;
  assign cs_act    = ~cs_r[STAGES-1];
  assign mosi_s    = mosi_r[STAGES-1];
endmodule

// File: rtl/spi_gpx_shift.sv
module spi_gpx_shift
  import spi_gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [1:0]        byte_idx,
  output logic              at_boundary
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt, bit_cnt_n;
  logic [BYTE_W-2:0] shreg, shreg_n;
  logic [1:0]        idx_n;

  assign byte_done   = cs_act & sclk_rise & (bit_cnt == CNT_W'(BYTE_W-1));
  assign byte_val    = {shreg, mosi_s};
  assign at_boundary = (bit_cnt == '0);

  always_comb begin
    bit_cnt_n = bit_cnt;
    shreg_n   = shreg;
    idx_n     = byte_idx;
    if (!cs_act) begin
      bit_cnt_n = '0;
      shreg_n   = '0;
      idx_n     = 2'd0;
    end else if (sclk_rise) begin
      bit_cnt_n = bit_cnt + CNT_W'(1);
      shreg_n   = {shreg[BYTE_W-3:0], mosi_s};
      if (byte_done && byte_idx != 2'd2) idx_n = byte_idx + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= 2'd0;
    end else begin
      bit_cnt  <= bit_cnt_n;
      shreg    <= shreg_n;
      byte_idx <= idx_n;
    end
  end
endmodule

// File: rtl/spi_gpx_ctrl.sv
module spi_gpx_ctrl
  import spi_gpx_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_act,
  input  logic                        sclk_fall,
  input  logic                        byte_done,
  input  logic [BYTE_W-1:0]           byte_val,
  input  logic [1:0]                  byte_idx,
  input  logic                        at_boundary,
  output logic [NUM_PORTS*BYTE_W-1:0] port_q,
  output logic                        miso
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PORTS-1);

  op_e               op, op_n;
  logic [IDX_W-1:0]  ptr, ptr_n;
  logic              ptr_ok, ptr_ok_n;
  logic [BYTE_W-1:0] tx, tx_n, rd_byte;
  logic              wr_en;
  logic [BYTE_W-1:0] port_r [NUM_PORTS];

  always_comb begin
    rd_byte = '0;
    for (int g = 0; g < NUM_PORTS; g++)
      if (ptr == IDX_W'(g)) rd_byte = port_r[g];
  end

  always_comb begin
    op_n     = op;
    ptr_n    = ptr;
    ptr_ok_n = ptr_ok;
    tx_n     = tx;
    wr_en    = 1'b0;
    if (!cs_act) begin
      op_n     = OP_NONE;
      ptr_n    = '0;
      ptr_ok_n = 1'b0;
      tx_n     = '0;
    end else begin
      if (byte_done) begin
        case (byte_idx)
          2'd0: begin
            if (byte_val == OPC_WRITE)     op_n = OP_WRITE;
            else if (byte_val == OPC_READ) op_n = OP_READ;
            else                           op_n = OP_BAD;
          end
          2'd1: begin
            ptr_n    = byte_val[BYTE_W-1 -: IDX_W];
            ptr_ok_n = int'(byte_val[BYTE_W-1 -: IDX_W]) < NUM_PORTS;
          end
          default: begin
            if (ptr_ok) begin
              wr_en = (op == OP_WRITE);
              if (ptr == LAST) ptr_ok_n = 1'b0;
              else             ptr_n    = ptr + IDX_W'(1);
            end
          end
        endcase
      end
      if (sclk_fall) begin
        if (at_boundary && byte_idx == 2'd2 && op == OP_READ)
          tx_n = ptr_ok ? rd_byte : '0;
        else
          tx_n = {tx[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op     <= OP_NONE;
      ptr    <= '0;
      ptr_ok <= 1'b0;
      tx     <= '0;
    end else begin
      op     <= op_n;
      ptr    <= ptr_n;
      ptr_ok <= ptr_ok_n;
      tx     <= tx_n;
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              port_r[g] <= '0;
      else if (wr_en && ptr == IDX_W'(g))      port_r[g] <= byte_val;
    end
    assign port_q[g*BYTE_W +: BYTE_W] = port_r[g];
  end

  assign miso = (op == OP_READ) & tx[BYTE_W-1];
endmodule

// File: rtl/spi_gpx_regif.sv
module spi_gpx_regif
  import spi_gpx_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_sclk,
  input  logic                        spi_cs_n,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic                        spi_miso_oe,
  output logic [NUM_PORTS*BYTE_W-1:0] port_q
);
  logic              sclk_rise, sclk_fall, cs_act, mosi_s;
  logic              byte_done, at_boundary;
  logic [BYTE_W-1:0] byte_val;
  logic [1:0]        byte_idx;

  spi_gpx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_gpx_shift shift_i (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .mosi_s(mosi_s), .byte_done(byte_done), .byte_val(byte_val),
    .byte_idx(byte_idx), .at_boundary(at_boundary)
  );

  spi_gpx_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx),
    .at_boundary(at_boundary), .port_q(port_q), .miso(spi_miso)
  );

  assign spi_miso_oe = cs_act;
endmodule

// File: rtl/spi_gpx_regif_chk.sv
module spi_gpx_regif_chk #(
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   spi_cs_n,
  input logic                   spi_miso_oe,
  input logic [NUM_PORTS*8-1:0] port_q
);
  localparam int HOLD = SYNC_STAGES + 2;

  logic [NUM_PORTS*8-1:0] prev_q;
  logic [NUM_PORTS-1:0]   chg;
  logic [7:0]             cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      cs_hi_cnt <= '0;
    end else begin
      prev_q <= port_q;
      if (!spi_cs_n)                cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 8'hFF)  cs_hi_cnt <= cs_hi_cnt + 8'd1;
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chg
    assign chg[g] = prev_q[g*8 +: 8] != port_q[g*8 +: 8];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (port_q == '0 && !spi_miso_oe)); // R1

  AST_ONE_PORT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1); // R4

  AST_IDLE_PORTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cs_hi_cnt) >= HOLD) |-> $stable(port_q)); // R9

  AST_IDLE_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cs_hi_cnt) >= HOLD) |-> !spi_miso_oe); // R10
endmodule

bind spi_gpx_regif spi_gpx_regif_chk #(
  .NUM_PORTS(NUM_PORTS), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
  .spi_miso_oe(spi_miso_oe), .port_q(port_q)
);

// File: tb/spi_gpx_regif_tb_top.sv
`timescale 1ns/1ps
module spi_gpx_regif_tb_top;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [15:0] port_q;

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  bit   mon_en = 0;
  logic [7:0] fbuf [8];
  logic [7:0] exp_q [$];
  string      mon_req = "R6";

  always #4 clk = ~clk;

  spi_gpx_regif dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .port_q(port_q)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Monitor: collects MISO bits in read data slots and compares with the queue
  initial begin
    logic [7:0] sh;
    int         n;
    n = 0;
    sh = '0;
    forever begin
      @(posedge spi_sclk);
      if (mon_en) begin
        sh = {sh[6:0], spi_miso};
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL %s actual=%h expected=none", mon_req, sh);
          end else begin
            check(mon_req, {8'h00, sh}, {8'h00, exp_q.pop_front()});
          end
        end
      end else begin
        n = 0;
      end
    end
  end

  // Driver: nbytes full bytes from fbuf, then xbits extra bits of ones
  task automatic frame(input int nbytes, input int xbits, input bit mon);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check("R10", {15'd0, spi_miso_oe}, 16'd1);
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (mon && i == 2 && b == 7) mon_en = 1;
        spi_mosi = fbuf[i][b];
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
      end
    end
    for (int k = 0; k < xbits; k++) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    mon_en = 0;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (3*HALF) @(negedge clk);
    check("R10", {15'd0, spi_miso_oe}, 16'd0);
  endtask

  function automatic void set4(input logic [7:0] a, b, c, d);
    fbuf[0] = a; fbuf[1] = b; fbuf[2] = c; fbuf[3] = d;
    fbuf[4] = 8'h00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1", port_q, 16'h0000);
    check("R1", {15'd0, spi_miso_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    set4(8'h03, 8'h00, 8'h5A, 8'h00); frame(3, 0, 0);
    check("R2", port_q, 16'h005A);

    set4(8'h03, 8'h10, 8'hC3, 8'h00); frame(3, 0, 0);
    check("R3", port_q, 16'hC35A);

    set4(8'h03, 8'h00, 8'hFF, 8'hFF); frame(4, 0, 0);
    check("R4", port_q, 16'hFFFF);

    set4(8'h03, 8'h00, 8'h12, 8'h34); frame(4, 0, 0);
    check("R4", port_q, 16'h3412);

    // R5: burst starting at last port, extra bytes must not wrap to port 0
    set4(8'h03, 8'h10, 8'hA5, 8'h77); fbuf[4] = 8'h99; frame(5, 0, 0);
    check("R5", port_q, 16'hA512);

    // R6: read burst from port 0, over-run slot returns 0x00
    mon_req = "R6";
    exp_q.push_back(8'h12); exp_q.push_back(8'hA5); exp_q.push_back(8'h00);
    set4(8'h02, 8'h00, 8'h00, 8'h00); frame(5, 0, 1);
    check("R6", 16'(exp_q.size()), 16'd0);

    // R3: read starting at port 1
    mon_req = "R3";
    exp_q.push_back(8'hA5); exp_q.push_back(8'h00);
    set4(8'h02, 8'h10, 8'h00, 8'h00); frame(4, 0, 1);
    check("R3", 16'(exp_q.size()), 16'd0);

    // R7: unknown opcode changes nothing and MISO stays 0
    mon_req = "R7";
    exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    set4(8'h07, 8'h00, 8'hEE, 8'hEE); frame(4, 0, 1);
    check("R7", port_q, 16'hA512);
    check("R7", 16'(exp_q.size()), 16'd0);

    // R8: one full byte then a 5-bit fragment
    set4(8'h03, 8'h00, 8'h66, 8'h00); frame(3, 5, 0);
    check("R8", port_q, 16'hA566);

    // R9: aborted header, then a fresh frame decodes from its first bit
    set4(8'h03, 8'h00, 8'h00, 8'h00); frame(1, 2, 0);
    check("R9", port_q, 16'hA566);
    set4(8'h03, 8'h10, 8'h3C, 8'h00); frame(3, 0, 0);
    check("R9", port_q, 16'h3C66);

    // R11: port index beyond last port drops all data
    set4(8'h03, 8'h20, 8'hDD, 8'hDD); frame(4, 0, 0);
    check("R11", port_q, 16'h3C66);

    report();
  end
endmodule